// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Walking Squash

This block keeps instructions from several hardware threads in program order until they retire. Dispatch writes an entry tagged with a thread number and a sequence number. Completion looks up a thread's entry by sequence number and marks it ready. Commit pops the head entry of a thread chosen by the caller. Each thread has its own circular queue, and one global capacity bounds the sum of all thread occupancies. A sharing policy chosen at run time sets how many entries each thread may hold.

A squash request names a thread and a sequence number. A walker starts at that thread's youngest entry and moves toward its head, flagging at most a fixed number of entries per cycle. It stops at the first entry whose sequence number is not larger than the request's number. Flagged entries stay in the queue and keep their count. They leave through the ordinary retire path, which reports them as dropped and not as committed. Per-thread and global status outputs let the front end throttle dispatch and let commit choose the oldest head.

Top module: `rob_mt`

## Requirements
- R1: After reset every thread is empty, the global free count equals the capacity, every squash-done flag is high, and the commit-possible output is low.
- R2: The global full output is high exactly when the occupied total equals the capacity. The global empty output is high exactly when the total is zero. The global free count equals capacity minus total.
- R3: Each thread has its own occupancy counter and limit. The thread full output is high when occupancy is at or above the limit, the empty output is high when occupancy is zero, and the free output equals the limit minus occupancy, floored at zero.
- R4: The policy input encoding is 0 for shared (every limit equals the capacity), 1 for split (an active thread's limit is the capacity divided by the number of set bits in the active mask, rounded down, and an inactive thread's limit is 0), and 2 for capped (every limit is capacity times the CAP_PCT parameter over 100, rounded down). Limits follow the policy and mask inputs combinationally.
- R5: An insert is rejected and not stored if the thread is at its limit, the buffer is globally full, the thread is walking a squash, or a squash for that thread arrives in the same cycle. A rejected insert raises insReject for one cycle, one cycle after the request.
- R6: A completion marks ready the valid entry of the named thread that holds the given sequence number. commitOk is high when at least one nonempty thread has a head entry that is ready and not squashed.
- R7: For each thread the block outputs the head sequence number, head ready flag, head squashed flag and youngest (tail) sequence number. The oldest head output gives the nonempty thread whose head has the smallest sequence number, with the lower thread number winning a tie.
- R8: A squash flags every entry of the named thread whose sequence number is larger than the request's number, compared as unsigned values. The walk goes from the tail toward the head and ends at the first entry that is not larger.
- R9: The walk flags at most SQ_WIDTH entries per cycle. A thread's done flag is low from the cycle after the request until the walk ends. The global done output is high only when every thread is done.
- R10: A squash does not move the tail and does not change occupancy. Squashed entries stay counted until they are retired.
- R11: Retiring a thread's head frees its entry. One cycle later commitPulse pulses if the head was not squashed, or dropPulse pulses if it was squashed.
- R12: A retire aimed at an empty thread changes nothing and raises neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Sharing policy: 0 shared, 1 split, 2 capped |
| activeMask | input | NT | Active threads, used by the split policy |
| insValid | input | 1 | Insert request |
| insTid | input | TW | Thread of the insert |
| insSeq | input | SW | Sequence number of the inserted entry |
| cmpValid | input | 1 | Completion request |
| cmpTid | input | TW | Thread of the completion |
| cmpSeq | input | SW | Sequence number to mark ready |
| retValid | input | 1 | Retire the head of a thread |
| retTid | input | TW | Thread to retire from |
| sqValid | input | 1 | Squash request |
| sqTid | input | TW | Thread to squash |
| sqSeq | input | SW | Entries younger than this are squashed |
| insReject | output | 1 | Previous insert was refused |
| commitPulse | output | 1 | Previous retire removed a live entry |
| dropPulse | output | 1 | Previous retire removed a squashed entry |
| thrFull | output | NT | Per-thread full |
| thrEmpty | output | NT | Per-thread empty |
| thrFree | output | NT*CW | Per-thread free entries |
| globFull | output | 1 | Buffer full |
| globEmpty | output | 1 | Buffer empty |
| globFree | output | CW | Free entries in the buffer |
| headSeq | output | NT*SW | Per-thread head sequence number |
| headRdy | output | NT | Per-thread head ready |
| headSq | output | NT | Per-thread head squashed |
| tailSeq | output | NT*SW | Per-thread youngest sequence number |
| oldestValid | output | 1 | Some thread is nonempty |
| oldestTid | output | TW | Thread with the oldest head |
| oldestSeq | output | SW | Sequence number of that head |
| commitOk | output | 1 | Some head is ready and live |
| thrSqDone | output | NT | Per-thread squash done |
| allSqDone | output | 1 | No thread is walking a squash |

## Verification
The bench runs a squash over three younger entries and checks that the done flag is still low after the first walking cycle. A walker that ignored the width limit would finish early, and one that never stopped at the older entry would flag live work. It retires across the boundary between live and squashed entries. A design that mixed up the two pulses, or that removed squashed entries at squash time, would show wrong pulses or a wrong free count. It also checks the split limits as the active mask changes, the rejection of inserts at the global limit and during a walk, retires from an empty thread, and head ordering across threads. A bad divisor, a missing guard or a wrong oldest-head comparison each shows up on these outputs.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    POL_SHARED = 2'd0,
    POL_SPLIT  = 2'd1,
    POL_CAP    = 2'd2
  } sharePolicy_e;

  typedef struct packed {
    logic insEn;
    logic cmpEn;
    logic retEn;
  } robStrobe_t;
endpackage

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int NE = 8,
  parameter int NT = 2,
  parameter int SW = 8,
  parameter int TW = 1,
  parameter int PW = 3,
  parameter int CW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  robStrobe_t stb,
  input  logic [TW-1:0] insTid,
  input  logic [SW-1:0] insSeq,
  input  logic [TW-1:0] cmpTid,
  input  logic [SW-1:0] cmpSeq,
  input  logic [TW-1:0] retTid,
  input  logic [NT-1:0][NE-1:0] markSq,
  output logic [NT-1:0][NE-1:0][SW-1:0] seqArr,
  output logic [NT-1:0][CW-1:0] cnt,
  output logic [NT-1:0][PW-1:0] tailPtr,
  output logic [NT-1:0][SW-1:0] headSeq,
  output logic [NT-1:0] headRdy,
  output logic [NT-1:0] headSq,
  output logic [NT-1:0][SW-1:0] tailSeq,
  output logic commitPulse,
  output logic dropPulse
);
  logic [NT-1:0][NE-1:0] rdyMem, sqMem, vld;
  logic [NT-1:0][PW-1:0] headPtr;
  logic [NT-1:0] retHit, insHit;

  function automatic logic [PW-1:0] ptrInc(input logic [PW-1:0] p);
    return (p == PW'(NE - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] ptrDec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(NE - 1) : p - 1'b1;
  endfunction

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      insHit[t]  = stb.insEn && (insTid == TW'(t));
      retHit[t]  = stb.retEn && (retTid == TW'(t)) && (cnt[t] != '0);
      headSeq[t] = seqArr[t][headPtr[t]];
      headRdy[t] = rdyMem[t][headPtr[t]];
      headSq[t]  = sqMem[t][headPtr[t]];
      tailSeq[t] = seqArr[t][ptrDec(tailPtr[t])];
      for (int i = 0; i < NE; i++) begin
        int off;
        off = (i >= int'(headPtr[t])) ? i - int'(headPtr[t]) : i + NE - int'(headPtr[t]);
        vld[t][i] = off < int'(cnt[t]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seqArr <= '0;
      rdyMem <= '0;
      sqMem <= '0;
      headPtr <= '0;
      tailPtr <= '0;
      cnt <= '0;
      commitPulse <= 1'b0;
      dropPulse <= 1'b0;
    end else begin
      commitPulse <= 1'b0;
      dropPulse <= 1'b0;
      for (int t = 0; t < NT; t++) begin
        for (int i = 0; i < NE; i++) begin
          if (markSq[t][i]) sqMem[t][i] <= 1'b1;
          if (stb.cmpEn && cmpTid == TW'(t) && vld[t][i] && seqArr[t][i] == cmpSeq)
            rdyMem[t][i] <= 1'b1;
        end
        if (insHit[t]) begin
          seqArr[t][tailPtr[t]] <= insSeq;
          rdyMem[t][tailPtr[t]] <= 1'b0;
          sqMem[t][tailPtr[t]] <= 1'b0;
          tailPtr[t] <= ptrInc(tailPtr[t]);
        end
        if (retHit[t]) begin
          headPtr[t] <= ptrInc(headPtr[t]);
          commitPulse <= !sqMem[t][headPtr[t]];
          dropPulse <= sqMem[t][headPtr[t]];
        end
        cnt[t] <= cnt[t] + CW'(insHit[t]) - CW'(retHit[t]);
      end
    end
  end
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int NE = 8,
  parameter int NT = 2,
  parameter int SW = 8,
  parameter int TW = 1,
  parameter int PW = 3,
  parameter int CW = 4,
  parameter int SQ_WIDTH = 2,
  parameter int CAP_PCT = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [1:0] policy,
  input  logic [NT-1:0] activeMask,
  input  logic insValid,
  input  logic [TW-1:0] insTid,
  input  logic cmpValid,
  input  logic retValid,
  input  logic [TW-1:0] retTid,
  input  logic sqValid,
  input  logic [TW-1:0] sqTid,
  input  logic [SW-1:0] sqSeq,
  input  logic [NT-1:0][NE-1:0][SW-1:0] seqArr,
  input  logic [NT-1:0][CW-1:0] cnt,
  input  logic [NT-1:0][PW-1:0] tailPtr,
  output robStrobe_t stb,
  output logic [NT-1:0][NE-1:0] markSq,
  output logic [NT-1:0][CW-1:0] limit,
  output logic [CW-1:0] total,
  output logic [NT-1:0] thrSqDone,
  output logic insReject
);
  localparam int CAP_LIM = (NE * CAP_PCT) / 100;

  logic [NT-1:0] walking, walkGoN, retHit;
  logic [NT-1:0][PW-1:0] walkPtr, walkPtrN;
  logic [NT-1:0][CW-1:0] walkLeft, walkLeftN, leftR;
  logic [NT-1:0][SW-1:0] walkSeq;
  logic accept;

  function automatic logic [PW-1:0] ptrDec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(NE - 1) : p - 1'b1;
  endfunction

  always_comb begin
    int numAct;
    numAct = $countones(activeMask);
    total = '0;
    for (int t = 0; t < NT; t++) begin
      total = total + cnt[t];
      case (sharePolicy_e'(policy))
        POL_SPLIT: limit[t] = (activeMask[t] && numAct != 0) ? CW'(NE / numAct) : '0;
        POL_CAP:   limit[t] = CW'(CAP_LIM);
        default:   limit[t] = CW'(NE);
      endcase
    end
  end

  assign accept = insValid && (cnt[insTid] < limit[insTid]) && (int'(total) < NE)
                  && !walking[insTid] && !(sqValid && sqTid == insTid);
  assign stb.insEn = accept;
  assign stb.cmpEn = cmpValid;
  assign stb.retEn = retValid;
  assign thrSqDone = ~walking;

  always_comb begin
    markSq = '0;
    for (int t = 0; t < NT; t++) begin
      retHit[t] = retValid && (retTid == TW'(t)) && (cnt[t] != '0);
      walkGoN[t] = walking[t];
      walkPtrN[t] = walkPtr[t];
      walkLeftN[t] = walkLeft[t];
      for (int k = 0; k < SQ_WIDTH; k++) begin
        if (walkGoN[t] && walkLeftN[t] != '0) begin
          if (seqArr[t][walkPtrN[t]] > walkSeq[t]) begin
            markSq[t][walkPtrN[t]] = 1'b1;
            walkPtrN[t] = ptrDec(walkPtrN[t]);
            walkLeftN[t] = walkLeftN[t] - 1'b1;
          end else begin
            walkGoN[t] = 1'b0;
          end
        end
      end
      leftR[t] = (retHit[t] && walkLeftN[t] != '0) ? walkLeftN[t] - 1'b1 : walkLeftN[t];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walking <= '0;
      walkPtr <= '0;
      walkLeft <= '0;
      walkSeq <= '0;
      insReject <= 1'b0;
    end else begin
      insReject <= insValid && !accept;
      for (int t = 0; t < NT; t++) begin
        if (sqValid && sqTid == TW'(t)) begin
          walking[t] <= 1'b1;
          walkPtr[t] <= ptrDec(tailPtr[t]);
          walkLeft[t] <= cnt[t] - CW'(retHit[t]);
          walkSeq[t] <= sqSeq;
        end else if (walking[t]) begin
          walking[t] <= walkGoN[t] && (leftR[t] != '0);
          walkPtr[t] <= walkPtrN[t];
          walkLeft[t] <= leftR[t];
        end
      end
    end
  end
endmodule

// File: rtl/rob_mt.sv
module rob_mt
  import rob_pkg::*;
#(
  parameter int NE = 8,
  parameter int NT = 2,
  parameter int SW = 8,
  parameter int SQ_WIDTH = 2,
  parameter int CAP_PCT = 75,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int PW = (NE > 1) ? $clog2(NE) : 1,
  localparam int CW = $clog2(NE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [1:0] policy,
  input  logic [NT-1:0] activeMask,
  input  logic insValid,
  input  logic [TW-1:0] insTid,
  input  logic [SW-1:0] insSeq,
  input  logic cmpValid,
  input  logic [TW-1:0] cmpTid,
  input  logic [SW-1:0] cmpSeq,
  input  logic retValid,
  input  logic [TW-1:0] retTid,
  input  logic sqValid,
  input  logic [TW-1:0] sqTid,
  input  logic [SW-1:0] sqSeq,
  output logic insReject,
  output logic commitPulse,
  output logic dropPulse,
  output logic [NT-1:0] thrFull,
  output logic [NT-1:0] thrEmpty,
  output logic [NT-1:0][CW-1:0] thrFree,
  output logic globFull,
  output logic globEmpty,
  output logic [CW-1:0] globFree,
  output logic [NT-1:0][SW-1:0] headSeq,
  output logic [NT-1:0] headRdy,
  output logic [NT-1:0] headSq,
  output logic [NT-1:0][SW-1:0] tailSeq,
  output logic oldestValid,
  output logic [TW-1:0] oldestTid,
  output logic [SW-1:0] oldestSeq,
  output logic commitOk,
  output logic [NT-1:0] thrSqDone,
  output logic allSqDone
);
  robStrobe_t stb;
  logic [NT-1:0][NE-1:0] markSq;
  logic [NT-1:0][NE-1:0][SW-1:0] seqArr;
  logic [NT-1:0][CW-1:0] cnt, limit;
  logic [NT-1:0][PW-1:0] tailPtr;
  logic [CW-1:0] total;

  rob_ctrl #(.NE(NE), .NT(NT), .SW(SW), .TW(TW), .PW(PW), .CW(CW),
             .SQ_WIDTH(SQ_WIDTH), .CAP_PCT(CAP_PCT)) ctrl (
    .clk(clk), .rst_n(rst_n), .policy(policy), .activeMask(activeMask),
    .insValid(insValid), .insTid(insTid), .cmpValid(cmpValid),
    .retValid(retValid), .retTid(retTid), .sqValid(sqValid), .sqTid(sqTid),
    .sqSeq(sqSeq), .seqArr(seqArr), .cnt(cnt), .tailPtr(tailPtr), .stb(stb),
    .markSq(markSq), .limit(limit), .total(total), .thrSqDone(thrSqDone),
    .insReject(insReject)
  );

  rob_store #(.NE(NE), .NT(NT), .SW(SW), .TW(TW), .PW(PW), .CW(CW)) store (
    .clk(clk), .rst_n(rst_n), .stb(stb), .insTid(insTid), .insSeq(insSeq),
    .cmpTid(cmpTid), .cmpSeq(cmpSeq), .retTid(retTid), .markSq(markSq),
    .seqArr(seqArr), .cnt(cnt), .tailPtr(tailPtr), .headSeq(headSeq),
    .headRdy(headRdy), .headSq(headSq), .tailSeq(tailSeq),
    .commitPulse(commitPulse), .dropPulse(dropPulse)
  );

  assign globFull = (int'(total) == NE);
  assign globEmpty = (total == '0);
  assign globFree = CW'(NE) - total;
  assign allSqDone = &thrSqDone;

  always_comb begin
    oldestValid = 1'b0;
    oldestTid = '0;
    oldestSeq = '0;
    commitOk = 1'b0;
    for (int t = 0; t < NT; t++) begin
      thrFull[t] = cnt[t] >= limit[t];
      thrEmpty[t] = cnt[t] == '0;
      thrFree[t] = (limit[t] > cnt[t]) ? limit[t] - cnt[t] : '0;
      if (cnt[t] != '0) begin
        if (headRdy[t] && !headSq[t]) commitOk = 1'b1;
        if (!oldestValid || headSeq[t] < oldestSeq) begin
          oldestValid = 1'b1;
          oldestTid = TW'(t);
          oldestSeq = headSeq[t];
        end
      end
    end
  end
endmodule

// File: rtl/rob_mt_checker.sv
module rob_mt_checker #(
  parameter int NT = 2,
  parameter int SW = 8,
  parameter int TW = 1,
  parameter int CW = 4
) (
  input logic clk,
  input logic rst_n,
  input logic insValid,
  input logic retValid,
  input logic [TW-1:0] retTid,
  input logic sqValid,
  input logic insReject,
  input logic commitPulse,
  input logic dropPulse,
  input logic [NT-1:0] thrEmpty,
  input logic globFull,
  input logic [CW-1:0] globFree,
  input logic [NT-1:0][SW-1:0] tailSeq,
  input logic allSqDone
);
  // R5
  full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insValid && globFull |=> insReject);
  // R12
  empty_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retValid && thrEmpty[retTid] |=> !commitPulse && !dropPulse);
  // R9
  squash_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sqValid |=> !allSqDone);
  // R10
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sqValid && !insValid |=> tailSeq == $past(tailSeq));
  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commitPulse, dropPulse}));
  // R2
  full_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    globFull == (globFree == '0));
endmodule

bind rob_mt rob_mt_checker #(.NT(NT), .SW(SW), .TW(TW), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .insValid(insValid), .retValid(retValid),
  .retTid(retTid), .sqValid(sqValid), .insReject(insReject),
  .commitPulse(commitPulse), .dropPulse(dropPulse), .thrEmpty(thrEmpty),
  .globFull(globFull), .globFree(globFree), .tailSeq(tailSeq),
  .allSqDone(allSqDone)
);

// File: tb/rob_mt_test.sv
module rob_mt_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] policy = 2'd2;
  logic [1:0] activeMask = 2'b11;
  logic insValid = 0, cmpValid = 0, retValid = 0, sqValid = 0;
  logic insTid = 0, cmpTid = 0, retTid = 0, sqTid = 0;
  logic [7:0] insSeq = 0, cmpSeq = 0, sqSeq = 0;
  logic insReject, commitPulse, dropPulse, globFull, globEmpty, oldestValid;
  logic oldestTid, commitOk, allSqDone;
  logic [1:0] thrFull, thrEmpty, headRdy, headSq, thrSqDone;
  logic [1:0][3:0] thrFree;
  logic [3:0] globFree;
  logic [1:0][7:0] headSeq, tailSeq;
  logic [7:0] oldestSeq;
  int checks = 0;
  int errors = 0;

  rob_mt uut (.*);

  always #2 clk = ~clk;

  // {tid, seq, expected reject, expected global free}
  localparam logic [13:0] VEC [0:8] = '{
    {1'b0, 8'd10, 1'b0, 4'd7}, {1'b0, 8'd11, 1'b0, 4'd6},
    {1'b0, 8'd12, 1'b0, 4'd5}, {1'b0, 8'd13, 1'b0, 4'd4},
    {1'b0, 8'd14, 1'b0, 4'd3}, {1'b0, 8'd15, 1'b0, 4'd2},
    {1'b0, 8'd16, 1'b1, 4'd2}, {1'b1, 8'd20, 1'b0, 4'd1},
    {1'b1, 8'd21, 1'b0, 4'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    insValid = 0; cmpValid = 0; retValid = 0; sqValid = 0;
  endtask

  task automatic ins(input logic t, input logic [7:0] s);
    insValid = 1; insTid = t; insSeq = s; tick();
  endtask

  task automatic ret(input logic t);
    retValid = 1; retTid = t; tick();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1; #0;
    // R1 reset state
    chk("R1", "globEmpty", globEmpty, 1);
    chk("R1", "globFree", globFree, 8);
    chk("R1", "allSqDone", allSqDone, 1);
    chk("R1", "commitOk", commitOk, 0);

    // R3 R4 R5 capped policy table: limit 6 per thread, global capacity 8
    for (int i = 0; i < 9; i++) begin
      ins(VEC[i][13], VEC[i][12:5]);
      chk("R5", "insReject", insReject, int'(VEC[i][4]));
      chk("R2", "globFree", globFree, int'(VEC[i][3:0]));
    end
    ins(1'b1, 8'd22);
    chk("R5", "reject when globally full", insReject, 1);
    chk("R2", "globFull", globFull, 1);
    chk("R3", "thrFull t0", thrFull[0], 1);
    chk("R3", "thrFree t1", thrFree[1], 4);

    // R7 heads and tails
    chk("R7", "headSeq t0", headSeq[0], 10);
    chk("R7", "tailSeq t0", tailSeq[0], 15);
    chk("R7", "oldestTid", oldestTid, 0);
    chk("R7", "oldestSeq", oldestSeq, 10);

    // R6 completion
    cmpValid = 1; cmpTid = 1; cmpSeq = 21; tick();
    chk("R6", "non-head ready gives no commit", commitOk, 0);
    cmpValid = 1; cmpTid = 1; cmpSeq = 20; tick();
    chk("R6", "headRdy t1", headRdy[1], 1);
    chk("R6", "commitOk", commitOk, 1);

    // R8 R9 R10 squash thread 0 above 12
    sqValid = 1; sqTid = 0; sqSeq = 12; tick();
    chk("R9", "t0 done low after request", thrSqDone[0], 0);
    chk("R9", "allSqDone low", allSqDone, 0);
    tick();
    chk("R9", "walk bounded by width", thrSqDone[0], 0);
    tick();
    chk("R9", "walk finished", thrSqDone[0], 1);
    chk("R10", "tail unchanged", tailSeq[0], 15);
    chk("R10", "occupancy unchanged", globFree, 0);

    // R11 retire live then squashed entries
    for (int i = 0; i < 3; i++) begin
      ret(1'b0);
      chk("R11", "commitPulse live", commitPulse, 1);
      chk("R8", "older entry not squashed", dropPulse, 0);
    end
    chk("R8", "first younger flagged", headSq[0], 1);
    for (int i = 0; i < 3; i++) begin
      ret(1'b0);
      chk("R11", "dropPulse squashed", dropPulse, 1);
      chk("R11", "no commitPulse", commitPulse, 0);
    end
    chk("R11", "freed entries", globFree, 6);

    // R12 retire from empty thread
    ret(1'b1); ret(1'b1);
    ret(1'b1);
    chk("R12", "no commitPulse", commitPulse, 0);
    chk("R12", "no dropPulse", dropPulse, 0);
    chk("R12", "free unchanged", globFree, 8);

    // R8 squash covering a whole thread, R5 insert during walk
    ins(1'b0, 8'd30); ins(1'b0, 8'd31); ins(1'b0, 8'd32);
    sqValid = 1; sqTid = 0; sqSeq = 5; tick();
    ins(1'b0, 8'd40);
    chk("R5", "insert rejected while walking", insReject, 1);
    tick();
    chk("R9", "whole-thread walk done", thrSqDone[0], 1);
    chk("R10", "count kept", thrFree[0], 3);
    ret(1'b0);
    chk("R8", "oldest flagged", dropPulse, 1);
    ret(1'b0); ret(1'b0);
    chk("R2", "globEmpty", globEmpty, 1);

    // R4 split policy
    policy = 2'd1; activeMask = 2'b01; #1;
    chk("R4", "inactive thread full", thrFull[1], 1);
    chk("R4", "sole thread limit", thrFree[0], 8);
    ins(1'b1, 8'd50);
    chk("R4", "inactive insert rejected", insReject, 1);
    activeMask = 2'b11; #1;
    chk("R4", "split free t0", thrFree[0], 4);
    for (int i = 0; i < 4; i++) ins(1'b0, 8'(70 + i));
    ins(1'b0, 8'd74);
    chk("R4", "split limit reject", insReject, 1);
    chk("R3", "thrFull t0 split", thrFull[0], 1);
    for (int i = 0; i < 4; i++) ret(1'b0);
    policy = 2'd0; #1;
    chk("R4", "shared limit", thrFree[1], 8);

    // R7 oldest across threads
    ins(1'b0, 8'd60); ins(1'b1, 8'd55);
    chk("R7", "oldestTid t1", oldestTid, 1);
    chk("R7", "oldestSeq", oldestSeq, 55);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule